// File: doc/BRIEF.md
# Multi-Level Idle Power Controller

This block watches two kinds of event input, general system activity and housekeeping activity, and walks a four-level power state machine from Active through Doze and Standby to Suspend as the idle time grows. Each of the three downward steps has its own inactivity limit. The limits are applied as parallel inputs, so they can be programmed from outside.

Housekeeping activity, such as periodic maintenance traffic, is not treated as a wakeup. In Doze or Standby a housekeeping event opens a service window of programmed length. While the window is open the power level is frozen and the running idle count pauses. When the window closes, the machine stays in the low-power level it was in and the idle count resumes from where it stopped. Any system-activity event returns the machine to Active. Every change of level raises a one-cycle interrupt.

Top module: `idle_pm_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, pm_state_o is 0 (Active), and state_irq_o and hk_open_o are 0.
- R2: In Active, the state becomes Doze (code 1) at the doze_tmo_i-th rising edge after the later of reset release and the last edge that sampled sys_act_i high.
- R3: In Doze, with no window open, the state becomes Standby (code 2) after stby_tmo_i counting edges. Counting starts from zero on entry to Doze.
- R4: In Standby, the state becomes Suspend (code 3) after susp_tmo_i counting edges, counted from zero on entry. Suspend is held until system activity arrives.
- R5: A limit of zero disables its step, and the machine stays in that level indefinitely.
- R6: An edge that samples sys_act_i high makes the state Active (code 0), closes any window and restarts the doze count. This takes priority over housekeeping events and over timer expiry on the same edge.
- R7: state_irq_o is high for exactly one cycle: the first cycle in which pm_state_o shows a new value. The state is encoded as 0 Active, 1 Doze, 2 Standby, 3 Suspend.
- R8: An edge that samples hk_act_i high in Doze or Standby, with hk_tmo_i nonzero, sets hk_open_o. hk_open_o clears at the hk_tmo_i-th edge after the last such event, so a new event restarts the window.
- R9: On an edge that samples a housekeeping event, and on every edge while hk_open_o is high, the power level is held and the level's idle count neither advances nor restarts.
- R10: Housekeeping events are ignored in Active and in Suspend, and whenever hk_tmo_i is zero. In those cases they neither open a window nor affect any idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_act_i | input | 1 | System activity event |
| hk_act_i | input | 1 | Housekeeping activity event |
| doze_tmo_i | input | CW | Idle cycles from Active to Doze, 0 disables |
| stby_tmo_i | input | CW | Idle cycles from Doze to Standby, 0 disables |
| susp_tmo_i | input | CW | Idle cycles from Standby to Suspend, 0 disables |
| hk_tmo_i | input | CW | Housekeeping window length, 0 disables |
| pm_state_o | output | 2 | Current power level |
| state_irq_o | output | 1 | One-cycle pulse on a level change |
| hk_open_o | output | 1 | Housekeeping window open |

## Verification
Two functions can claim the same edge. The first is a housekeeping event arriving on the very edge at which the Doze or Standby count would expire. The second is system activity coinciding with a housekeeping event or with an open window. Directed sequences place a housekeeping pulse on the cycle right after entry to Doze and place sys_act_i and hk_act_i together. A long random run with short limits makes both collisions frequent. A cycle model in the bench, built from R2 through R10, judges every cycle, so a held level, a paused count, the window edges and wake priority are each checked against the cycle in which they must appear.

// File: rtl/idle_pm_pkg.sv
package idle_pm_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_DOZE   = 2'd1,
    PM_STBY   = 2'd2,
    PM_SUSP   = 2'd3
  } pm_state_e;

  localparam int unsigned PM_LEVELS = 3;
endpackage

// File: rtl/pm_idle_cnt.sv
module pm_idle_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          hold_i,
  input  logic [CW-1:0] limit_i,
  output logic          exp_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;
  logic          en;

  assign en    = (limit_i != '0);
  // elapsed count compared to the live limit; expires on the limit-th counting edge
  assign exp_o = !clr_i && !hold_i && en && (cnt_q == limit_i - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || exp_o)    cnt_q <= '0;
    else if (!hold_i && en)     cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
  import idle_pm_pkg::*;
#(
  parameter int unsigned NL = PM_LEVELS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sys_act_i,
  input  logic          hk_evt_i,
  input  logic          hk_exp_i,
  input  logic [NL-1:0] lvl_exp_i,
  output pm_state_e     state_o,
  output logic          irq_o,
  output logic          hk_open_o
);
  pm_state_e st_q, st_d;
  logic      open_q, open_d, irq_q;

  always_comb begin
    st_d   = st_q;
    open_d = open_q;
    if (sys_act_i) begin
      st_d   = PM_ACTIVE;
      open_d = 1'b0;
    end else begin
      if (hk_evt_i)      open_d = 1'b1;
      else if (hk_exp_i) open_d = 1'b0;
      unique case (st_q)
        PM_ACTIVE: if (lvl_exp_i[0]) st_d = PM_DOZE;
        PM_DOZE:   if (lvl_exp_i[1]) st_d = PM_STBY;
        PM_STBY:   if (lvl_exp_i[2]) st_d = PM_SUSP;
        default:   st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PM_ACTIVE;
      open_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      open_q <= open_d;
      irq_q  <= (st_d != st_q);
    end
  end

  assign state_o   = st_q;
  assign irq_o     = irq_q;
  assign hk_open_o = open_q;
endmodule

// File: rtl/idle_pm_ctrl.sv
module idle_pm_ctrl
  import idle_pm_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sys_act_i,
  input  logic          hk_act_i,
  input  logic [CW-1:0] doze_tmo_i,
  input  logic [CW-1:0] stby_tmo_i,
  input  logic [CW-1:0] susp_tmo_i,
  input  logic [CW-1:0] hk_tmo_i,
  output logic [1:0]    pm_state_o,
  output logic          state_irq_o,
  output logic          hk_open_o
);
  localparam int unsigned NL = PM_LEVELS;

  pm_state_e        st;
  logic [CW-1:0]    lvl_tmo [NL];
  logic [NL-1:0]    lvl_exp;
  logic             hk_open, hk_evt, hk_exp, lvl_hold;

  assign lvl_tmo[0] = doze_tmo_i;
  assign lvl_tmo[1] = stby_tmo_i;
  assign lvl_tmo[2] = susp_tmo_i;

  // housekeeping counts only in the two shallow sleep levels
  assign hk_evt   = hk_act_i && !sys_act_i && (hk_tmo_i != '0) &&
                    ((st == PM_DOZE) || (st == PM_STBY));
  assign lvl_hold = hk_open || hk_evt;

  for (genvar i = 0; i < NL; i++) begin : g_lvl
    pm_idle_cnt #(.CW(CW)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (sys_act_i || (st != pm_state_e'(i))),
      .hold_i  (lvl_hold),
      .limit_i (lvl_tmo[i]),
      .exp_o   (lvl_exp[i])
    );
  end

  pm_idle_cnt #(.CW(CW)) u_hk_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (hk_evt || !hk_open),
    .hold_i  (1'b0),
    .limit_i (hk_tmo_i),
    .exp_o   (hk_exp)
  );

  pm_state_fsm #(.NL(NL)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_act_i (sys_act_i),
    .hk_evt_i  (hk_evt),
    .hk_exp_i  (hk_exp),
    .lvl_exp_i (lvl_exp),
    .state_o   (st),
    .irq_o     (state_irq_o),
    .hk_open_o (hk_open)
  );

  assign pm_state_o = st;
  assign hk_open_o  = hk_open;
endmodule

// File: rtl/idle_pm_chk.sv
module idle_pm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sys_act_i,
  input logic       hk_act_i,
  input logic [1:0] pm_state_o,
  input logic       state_irq_o,
  input logic       hk_open_o
);
  AST_WAKE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_act_i |=> (pm_state_o == 2'd0 && !hk_open_o)); // R6

  AST_IRQ_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_irq_o == (pm_state_o != $past(pm_state_o))); // R7

  AST_STEP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_state_o != $past(pm_state_o)) |->
      (pm_state_o == 2'd0 || pm_state_o == $past(pm_state_o) + 2'd1)); // R3

  AST_WINDOW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hk_open_o && !sys_act_i) |=> $stable(pm_state_o)); // R9

  AST_WINDOW_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hk_open_o |-> (pm_state_o == 2'd1 || pm_state_o == 2'd2)); // R8

  AST_SUSP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_state_o == 2'd3 && !sys_act_i) |=> (pm_state_o == 2'd3 && !hk_open_o)); // R10

  AST_NO_HK_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hk_act_i && !sys_act_i && pm_state_o != 2'd0) |=> (pm_state_o != 2'd0)); // R10
endmodule

bind idle_pm_ctrl idle_pm_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sys_act_i   (sys_act_i),
  .hk_act_i    (hk_act_i),
  .pm_state_o  (pm_state_o),
  .state_irq_o (state_irq_o),
  .hk_open_o   (hk_open_o)
);

// File: tb/tb_idle_pm_ctrl.sv
module tb_idle_pm_ctrl;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sys_act = 1'b0, hk_act = 1'b0;
  logic [CW-1:0] doze_tmo = 8'd4, stby_tmo = 8'd3, susp_tmo = 8'd2, hk_tmo = 8'd3;
  logic [1:0]    pm_state;
  logic          irq, hk_open;

  int n_chk = 0, n_bad = 0, n_cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  idle_pm_ctrl #(.CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sys_act_i(sys_act), .hk_act_i(hk_act),
    .doze_tmo_i(doze_tmo), .stby_tmo_i(stby_tmo), .susp_tmo_i(susp_tmo),
    .hk_tmo_i(hk_tmo), .pm_state_o(pm_state), .state_irq_o(irq), .hk_open_o(hk_open)
  );

  // cycle model built from the requirements
  int m_st = 0, m_el = 0, m_hel = 0;
  bit m_open = 0, m_irq = 0;

  function automatic int lvl_limit(int st);
    case (st)
      0: return int'(doze_tmo);
      1: return int'(stby_tmo);
      2: return int'(susp_tmo);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_el = 0; m_hel = 0; m_open = 0; m_irq = 0;
    end else begin
      int nst, nel, nhel, lim;
      bit nopen, evt;
      evt  = hk_act && !sys_act && (m_st == 1 || m_st == 2) && hk_tmo != 0;
      nst = m_st; nel = m_el; nhel = m_hel; nopen = m_open;
      if (sys_act) begin
        nst = 0; nel = 0; nhel = 0; nopen = 0;
      end else begin
        lim = lvl_limit(m_st);
        if (m_st != 3 && !(m_open || evt) && lim != 0) begin
          if (m_el == lim - 1) begin nst = m_st + 1; nel = 0; end
          else nel = m_el + 1;
        end
        if (evt) begin nopen = 1; nhel = 0; end
        else if (m_open && hk_tmo != 0) begin
          if (m_hel == int'(hk_tmo) - 1) begin nopen = 0; nhel = 0; end
          else nhel = m_hel + 1;
        end
      end
      m_irq = (nst != m_st);
      m_st = nst; m_el = nel; m_hel = nhel; m_open = nopen;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R3/R4/R6/R9 model state", int'(pm_state), m_st);
      chk("R7 model irq", int'(irq), int'(m_irq));
      chk("R8/R10 model window", int'(hk_open), int'(m_open));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sys();
    sys_act = 1'b1; cyc(1); sys_act = 1'b0;
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", n_cyc, 150000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d1e_5eed));
    cyc(3);
    chk("R1 state in reset", int'(pm_state), 0);
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 window in reset", int'(hk_open), 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 state after release", int'(pm_state), 0);
    chk("R1 irq after release", int'(irq), 0);
    cyc(2);
    chk("R2 still active", int'(pm_state), 0);
    cyc(1);
    chk("R2 doze entry", int'(pm_state), 1);
    chk("R7 irq on doze", int'(irq), 1);
    cyc(1);
    chk("R7 irq single cycle", int'(irq), 0);
    cyc(1);
    chk("R3 still doze", int'(pm_state), 1);
    cyc(1);
    chk("R3 standby entry", int'(pm_state), 2);
    cyc(1);
    chk("R4 still standby", int'(pm_state), 2);
    cyc(1);
    chk("R4 suspend entry", int'(pm_state), 3);
    cyc(10);
    chk("R4 suspend held", int'(pm_state), 3);
    hk_act = 1'b1; cyc(1); hk_act = 1'b0;
    chk("R10 hk in suspend no window", int'(hk_open), 0);
    chk("R10 hk in suspend state", int'(pm_state), 3);
    pulse_sys();
    chk("R6 wake from suspend", int'(pm_state), 0);
    chk("R7 irq on wake", int'(irq), 1);

    // window holds level and pauses the idle count
    cyc(4);
    chk("R2 doze again", int'(pm_state), 1);
    hk_act = 1'b1; cyc(1); hk_act = 1'b0;
    chk("R8 window opens", int'(hk_open), 1);
    cyc(2);
    chk("R8 window still open", int'(hk_open), 1);
    chk("R9 level held", int'(pm_state), 1);
    cyc(1);
    chk("R8 window closes", int'(hk_open), 0);
    cyc(2);
    chk("R9 count paused, still doze", int'(pm_state), 1);
    cyc(1);
    chk("R9 standby after resumed count", int'(pm_state), 2);
    hk_act = 1'b1; cyc(2); hk_act = 1'b0;
    chk("R8 retrigger open", int'(hk_open), 1);
    cyc(2);
    chk("R8 retrigger extends", int'(hk_open), 1);
    cyc(1);
    chk("R8 retrigger close", int'(hk_open), 0);
    chk("R9 standby kept", int'(pm_state), 2);

    // same-cycle collision
    pulse_sys();
    cyc(4);
    chk("R2 doze before collision", int'(pm_state), 1);
    sys_act = 1'b1; hk_act = 1'b1; cyc(1); sys_act = 1'b0; hk_act = 1'b0;
    chk("R6 sys beats hk state", int'(pm_state), 0);
    chk("R6 sys beats hk window", int'(hk_open), 0);

    // window disabled
    hk_tmo = 8'd0;
    cyc(4);
    chk("R2 doze with hk off", int'(pm_state), 1);
    hk_act = 1'b1; cyc(1); hk_act = 1'b0;
    chk("R10 hk off no window", int'(hk_open), 0);
    cyc(1);
    chk("R10 idle count unaffected", int'(pm_state), 1);
    cyc(1);
    chk("R10 standby on time", int'(pm_state), 2);

    // zero limits
    doze_tmo = 8'd0; pulse_sys();
    cyc(30);
    chk("R5 doze disabled", int'(pm_state), 0);
    doze_tmo = 8'd2; stby_tmo = 8'd0; pulse_sys();
    cyc(2);
    chk("R2 short doze", int'(pm_state), 1);
    cyc(30);
    chk("R5 standby disabled", int'(pm_state), 1);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 80 == 0) begin
        doze_tmo = CW'($urandom_range(0, 5));
        stby_tmo = CW'($urandom_range(0, 5));
        susp_tmo = CW'($urandom_range(0, 5));
        hk_tmo   = CW'($urandom_range(0, 5));
        sys_act  = 1'b1;
        hk_act   = 1'($urandom_range(0, 1));
      end else begin
        sys_act = ($urandom_range(0, 59) == 0);
        hk_act  = ($urandom_range(0, 4) == 0);
      end
      cyc(1);
    end
    sys_act = 1'b0; hk_act = 1'b0;
    cyc(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule